// File: doc/BRIEF.md
# Short Branch and Predicate-Flag Decoder

This block decodes the short branch group of compact 17-bit instructions. Each word is 16 stream bits plus one header bit. For a branch it tests a 4-bit condition selector against the carry, zero and overflow flags and reports whether the branch is taken. It also forms the PC-relative target from a signed 8-bit halfword displacement, added to the address of the next instruction.

Four selector values never branch. Three of them update the predication flag from a condition named in the low bits of the displacement field: write it, set it on the condition, or clear it on the condition. The fourth requests a supervisor call. One selector value is reserved and does nothing.

The unit sits between instruction decode and the fetch redirect. It has one registered stage. It samples the instruction, the next-instruction address, the flags and the current predication flag on every clock edge, and presents its results from that edge on. Fetch, the pipeline and trap entry live outside it.

Top module: `sbr_unit`

## Requirements
- R1: While reset is asserted and on the first edge after it, `taken_o`, `svc_o`, `pred_o` and `target_o` are all zero.
- R2: A word belongs to the group when bits 16:12 equal 5'b11100. Bits 11:8 are the selector and bits 7:0 the displacement. Results for inputs sampled on one rising edge appear after that edge and not before it.
- R3: Branch selectors and their conditions: 1 carry set, 2 zero set, 3 carry or zero, 4 carry clear and zero clear, 5 zero clear, 6 carry clear, 7 overflow clear, 8 overflow set, 10 carry set, 11 carry clear. `taken_o` is 1 exactly when the condition holds.
- R4: Selector 15 is taken regardless of the flags.
- R5: For a taken branch, `target_o` equals the next-instruction address plus the sign-extended displacement times two, modulo 2^ADDR_W. A displacement of 0 gives the next address itself, -128 gives it minus 256, and +127 gives it plus 254.
- R6: Selector 0 writes the predication flag to 1 when the condition named by displacement bits 3:0 holds, and to 0 otherwise.
- R7: Selector 12 sets the predication flag to 1 when that condition holds and otherwise passes the current value through.
- R8: Selector 13 clears the predication flag to 0 when that condition holds and otherwise passes the current value through.
- R9: Selector 14 raises `svc_o`, does not branch, and leaves the predication flag unchanged.
- R10: Selector 9, and any word outside the group, gives no branch, no supervisor call, and a predication flag equal to the current one.
- R11: In the flag forms, a condition code that names no branch condition (0, 9, 12, 13, 14) counts as not holding. Code 15 always holds.
- R12: Selectors 0, 12 and 13 never assert `taken_o` or `svc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 17 | Instruction: header bit 16 plus the 16 stream bits |
| next_pc_i | input | ADDR_W | Byte address of the halfword after the instruction |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| vf_i | input | 1 | Overflow flag |
| pred_i | input | 1 | Current predication flag |
| taken_o | output | 1 | Branch taken |
| target_o | output | ADDR_W | Branch target address |
| pred_o | output | 1 | Next value of the predication flag |
| svc_o | output | 1 | Supervisor-call request |

## Verification
All four results are due exactly one rising edge after their inputs are sampled. Nothing is visible before that edge.

Each bench task drives its inputs on a falling edge and waits for the next rising edge. It reads the outputs on the falling edge that follows. One dedicated check looks just before the rising edge to confirm the old value still holds. The in-design properties compare each output with the `$past` inputs of the previous cycle, so they line up with the same one-edge delay.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int INSN_W = 17;
    localparam int TAG_W  = 5;
    localparam int SEL_W  = 4;
    localparam int DISP_W = 8;

    localparam logic [TAG_W-1:0] GROUP_TAG = 5'b11100;

    // selector values with a fixed meaning
    localparam logic [SEL_W-1:0] SEL_TEST   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_LO     = 4'd1;
    localparam logic [SEL_W-1:0] SEL_EQ     = 4'd2;
    localparam logic [SEL_W-1:0] SEL_LE     = 4'd3;
    localparam logic [SEL_W-1:0] SEL_HI     = 4'd4;
    localparam logic [SEL_W-1:0] SEL_NE     = 4'd5;
    localparam logic [SEL_W-1:0] SEL_HE     = 4'd6;
    localparam logic [SEL_W-1:0] SEL_NOVF   = 4'd7;
    localparam logic [SEL_W-1:0] SEL_OVF    = 4'd8;
    localparam logic [SEL_W-1:0] SEL_RSVD   = 4'd9;
    localparam logic [SEL_W-1:0] SEL_CY     = 4'd10;
    localparam logic [SEL_W-1:0] SEL_NCY    = 4'd11;
    localparam logic [SEL_W-1:0] SEL_SET    = 4'd12;
    localparam logic [SEL_W-1:0] SEL_CLEAR  = 4'd13;
    localparam logic [SEL_W-1:0] SEL_TRAP   = 4'd14;
    localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'd15;

    typedef enum logic [2:0] {
        K_NONE,
        K_BRANCH,
        K_TEST,
        K_SET,
        K_CLEAR,
        K_TRAP
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [SEL_W-1:0]   sel;
        logic [DISP_W-1:0]  disp;
    } dec_t;

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
    import sbr_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);

    logic in_group;

    assign in_group = (insn_i[INSN_W-1 -: TAG_W] == GROUP_TAG);

    always_comb begin
        dec_o      = '0;
        dec_o.sel  = insn_i[DISP_W +: SEL_W];
        dec_o.disp = insn_i[DISP_W-1:0];
        dec_o.kind = K_NONE;
        if (in_group) begin
            unique case (insn_i[DISP_W +: SEL_W])
                SEL_TEST:  dec_o.kind = K_TEST;
                SEL_RSVD:  dec_o.kind = K_NONE;
                SEL_SET:   dec_o.kind = K_SET;
                SEL_CLEAR: dec_o.kind = K_CLEAR;
                SEL_TRAP:  dec_o.kind = K_TRAP;
                default:   dec_o.kind = K_BRANCH;
            endcase
        end
    end

endmodule

// File: rtl/sbr_cond_eval.sv
module sbr_cond_eval
    import sbr_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic             cf_i,
    input  logic             zf_i,
    input  logic             vf_i,
    output logic             hold_o
);

    always_comb begin
        unique case (sel_i)
            SEL_LO:     hold_o = cf_i;
            SEL_EQ:     hold_o = zf_i;
            SEL_LE:     hold_o = cf_i | zf_i;
            SEL_HI:     hold_o = ~cf_i & ~zf_i;
            SEL_NE:     hold_o = ~zf_i;
            SEL_HE:     hold_o = ~cf_i;
            SEL_NOVF:   hold_o = ~vf_i;
            SEL_OVF:    hold_o = vf_i;
            SEL_CY:     hold_o = cf_i;
            SEL_NCY:    hold_o = ~cf_i;
            SEL_ALWAYS: hold_o = 1'b1;
            default:    hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbr_target.sv
module sbr_target #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DISP_W - 1;

    logic [ADDR_W-1:0] offset;

    // halfword units: sign extend, then shift left by one
    assign offset   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 1'b0};
    assign target_o = next_pc_i + offset;

endmodule

// File: rtl/sbr_unit.sv
module sbr_unit
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [16:0]       insn_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic              cf_i,
    input  logic              zf_i,
    input  logic              vf_i,
    input  logic              pred_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              pred_o,
    output logic              svc_o
);

    localparam int N_EVAL = 2;   // 0: branch selector, 1: flag-form test code

    dec_t                    dec;
    logic [N_EVAL-1:0]       hold;
    logic [SEL_W-1:0]        eval_sel [N_EVAL];
    logic [ADDR_W-1:0]       target_d;
    logic                    taken_d, pred_d, svc_d;
    logic                    taken_q, pred_q, svc_q;
    logic [ADDR_W-1:0]       target_q;
    logic                    live_q;

    sbr_decode u_decode (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    assign eval_sel[0] = dec.sel;
    assign eval_sel[1] = dec.disp[SEL_W-1:0];

    for (genvar g = 0; g < N_EVAL; g++) begin : g_eval
        sbr_cond_eval u_eval (
            .sel_i  (eval_sel[g]),
            .cf_i   (cf_i),
            .zf_i   (zf_i),
            .vf_i   (vf_i),
            .hold_o (hold[g])
        );
    end

    sbr_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_target (
        .next_pc_i (next_pc_i),
        .disp_i    (dec.disp),
        .target_o  (target_d)
    );

    // result selection per decoded kind
    always_comb begin
        taken_d = 1'b0;
        svc_d   = 1'b0;
        pred_d  = pred_i;
        unique case (dec.kind)
            K_BRANCH: taken_d = hold[0];
            K_TEST:   pred_d  = hold[1];
            K_SET:    if (hold[1]) pred_d = 1'b1;
            K_CLEAR:  if (hold[1]) pred_d = 1'b0;
            K_TRAP:   svc_d   = 1'b1;
            default:  ;
        endcase
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q  <= 1'b0;
            svc_q    <= 1'b0;
            pred_q   <= 1'b0;
            target_q <= '0;
            live_q   <= 1'b0;
        end else begin
            taken_q  <= taken_d;
            svc_q    <= svc_d;
            pred_q   <= pred_d;
            target_q <= target_d;
            live_q   <= 1'b1;
        end
    end

    assign taken_o  = taken_q;
    assign svc_o    = svc_q;
    assign pred_o   = pred_q;
    assign target_o = target_q;

    // ---------------- assertions ----------------
    p_always_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(insn_i[16:12]) == GROUP_TAG && $past(insn_i[11:8]) == SEL_ALWAYS)
        |-> taken_o);

    p_zero_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && taken_o && $past(insn_i[7:0]) == 8'd0)
        |-> target_o == $past(next_pc_i));

    p_set_keeps_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(insn_i[16:12]) == GROUP_TAG && $past(insn_i[11:8]) == SEL_SET && $past(pred_i))
        |-> pred_o);

    p_clear_keeps_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(insn_i[16:12]) == GROUP_TAG && $past(insn_i[11:8]) == SEL_CLEAR && !$past(pred_i))
        |-> !pred_o);

    p_trap_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(insn_i[16:12]) == GROUP_TAG && $past(insn_i[11:8]) == SEL_TRAP)
        |-> (svc_o && !taken_o && pred_o == $past(pred_i)));

    p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(insn_i[16:12]) != GROUP_TAG)
        |-> (!taken_o && !svc_o && pred_o == $past(pred_i)));

endmodule

// File: tb/sbr_unit_bench.sv
module sbr_unit_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [16:0]   insn = '0;
    logic [AW-1:0] next_pc = '0;
    logic          cf = 1'b0, zf = 1'b0, vf = 1'b0, pred = 1'b0;
    logic          taken, pred_out, svc;
    logic [AW-1:0] target;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sbr_unit #(.ADDR_W(AW)) u_sbr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_i    (insn),
        .next_pc_i (next_pc),
        .cf_i      (cf),
        .zf_i      (zf),
        .vf_i      (vf),
        .pred_i    (pred),
        .taken_o   (taken),
        .target_o  (target),
        .pred_o    (pred_out),
        .svc_o     (svc)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(input logic [3:0] sel, input logic [7:0] disp);
        return {5'b11100, sel, disp};
    endfunction

    // condition table from the requirements (R3, R4, R11)
    function automatic logic ref_cond(input logic [3:0] code, input logic c, input logic z, input logic v);
        case (code)
            4'd1, 4'd10: return c;
            4'd2:        return z;
            4'd3:        return c | z;
            4'd4:        return !c && !z;
            4'd5:        return !z;
            4'd6, 4'd11: return !c;
            4'd7:        return !v;
            4'd8:        return v;
            4'd15:       return 1'b1;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic bit is_branch(input logic [3:0] sel);
        return !(sel inside {4'd0, 4'd9, 4'd12, 4'd13, 4'd14});
    endfunction

    task automatic drive(input logic [16:0] ins, input logic [AW-1:0] pc,
                         input logic c, input logic z, input logic v, input logic p);
        @(negedge clk);
        insn = ins; next_pc = pc; cf = c; zf = z; vf = v; pred = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        insn = mk(4'd15, 8'h10); next_pc = 32'h100; pred = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 taken in reset", AW'(taken), '0);
        chk("R1 svc in reset", AW'(svc), '0);
        chk("R1 pred in reset", AW'(pred_out), '0);
        chk("R1 target in reset", target, '0);
        insn = '0; pred = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        drive(17'h00000, 32'h200, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        insn = mk(4'd15, 8'h00); next_pc = 32'h300;
        @(posedge clk);
        #4;
        chk("R2 result after edge", AW'(taken), 1);
        chk("R2 target after edge", target, 32'h300);
        @(negedge clk);
        insn = 17'h00000;
        #4;
        chk("R2 no change before edge", AW'(taken), 1);
        @(posedge clk);
        #1;
        chk("R2 cleared after edge", AW'(taken), 0);
    endtask

    task automatic t_branch_table();
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 8; f++) begin
                logic c, z, v, p, exp_t;
                c = f[0]; z = f[1]; v = f[2]; p = f[0] ^ f[2];
                drive(mk(4'(s), 8'h05), 32'h1000, c, z, v, p);
                exp_t = is_branch(4'(s)) && ref_cond(4'(s), c, z, v);
                if (s == 15)
                    chk("R4 unconditional taken", AW'(taken), AW'(exp_t));
                else if (s == 9)
                    chk("R10 reserved no branch", AW'(taken), 0);
                else if (s == 14)
                    chk("R9 trap no branch", AW'(taken), 0);
                else if (!is_branch(4'(s)))
                    chk("R12 flag form no branch", AW'(taken), 0);
                else
                    chk("R3 branch condition", AW'(taken), AW'(exp_t));
                if (s == 14) begin
                    chk("R9 trap raised", AW'(svc), 1);
                    chk("R9 trap keeps pred", AW'(pred_out), AW'(p));
                end else begin
                    chk("R12 no trap", AW'(svc), 0);
                end
                if (is_branch(4'(s)) || s == 9)
                    chk("R10 pred passes", AW'(pred_out), AW'(p));
            end
        end
    endtask

    task automatic t_target();
        logic [AW-1:0] pcs [5] = '{32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'hFFFF_FFFE};
        logic [7:0]    ds  [5] = '{8'h00, 8'h80, 8'h7F, 8'hFF, 8'h01};
        logic [AW-1:0] ex  [5] = '{32'h0000_1000, 32'h0000_0F00, 32'h0000_10FE, 32'h0000_0FFE, 32'h0000_0000};
        for (int i = 0; i < 5; i++) begin
            drive(mk(4'd15, ds[i]), pcs[i], 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R5 target", target, ex[i]);
        end
        drive(mk(4'd2, 8'hF0), 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 conditional target", target, 32'h0000_3FE0);
    endtask

    task automatic t_flag_forms();
        logic [3:0] ops [3] = '{4'd0, 4'd12, 4'd13};
        for (int o = 0; o < 3; o++) begin
            for (int code = 0; code < 16; code++) begin
                for (int f = 0; f < 16; f++) begin
                    logic c, z, v, p, h, e;
                    c = f[0]; z = f[1]; v = f[2]; p = f[3];
                    drive(mk(ops[o], {4'hA, 4'(code)}), 32'h2000, c, z, v, p);
                    h = ref_cond(4'(code), c, z, v);
                    if (o == 0)      e = h;
                    else if (o == 1) e = h ? 1'b1 : p;
                    else             e = h ? 1'b0 : p;
                    if (!is_branch(4'(code)))
                        chk("R11 invalid test code", AW'(pred_out), AW'(e));
                    else if (o == 0)
                        chk("R6 write flag", AW'(pred_out), AW'(e));
                    else if (o == 1)
                        chk("R7 set flag", AW'(pred_out), AW'(e));
                    else
                        chk("R8 clear flag", AW'(pred_out), AW'(e));
                    chk("R12 flag form quiet", AW'({taken, svc}), 0);
                end
            end
        end
    endtask

    task automatic t_outside();
        logic [16:0] words [4] = '{17'h00000, 17'h1F4FF, 17'h1B4FF, 17'h1D8FF};
        for (int i = 0; i < 4; i++) begin
            for (int p = 0; p < 2; p++) begin
                drive(words[i], 32'h3000, 1'b1, 1'b1, 1'b1, 1'(p));
                chk("R10 outside no branch", AW'(taken), 0);
                chk("R10 outside no trap", AW'(svc), 0);
                chk("R10 outside pred", AW'(pred_out), AW'(p));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_branch_table();
        t_target();
        t_flag_forms();
        t_outside();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule